// File: doc/BRIEF.md
# Interrupt Expander Register Block

This block merges up to sixteen peripheral interrupt requests into one level-sensitive, active-low interrupt line for a host processor. Each request passes through a synchronizer and is captured in a sticky status bit. A mask register selects which captured bits may drive the host line. A clear register whose bits are held by software erases status bits. Software sets a clear bit to one and then writes it back to zero.

A small synchronous 16-bit register port gives access to status, mask and clear. Three fixed signature words let software probe for the block before it enables anything. A version word returns a build-time constant. Read data is registered. Line 0 comes from a source whose request is active low, so the block inverts it before synchronizing.

Top module: `irqx_top`

## Requirements
- R1: After reset the mask reads 0xFFFF, the clear register reads 0x0000, status reads 0x0000, irq_no is high and rdata_o is 0.
- R2: A request that stays active for at least two clock cycles sets its status bit. The bit stays set after the request goes away, until it is cleared.
- R3: Reads at offset 0x40 return 0xAAAA, at 0x48 return 0x5555 and at 0x58 return 0xCAFE. Writes to these offsets change nothing.
- R4: A read at offset 0x50 returns the VERSION parameter (default 0x0107).
- R5: While bit i of the clear register (offset 0x20) is 1, status bit i is held at 0, even if request i stays active. After the bit returns to 0, a request that is still active sets the status bit again.
- R6: irq_no is low exactly when some status bit is set and its mask bit (offset 0x38) is 0. A mask bit of 1 keeps that line from driving irq_no.
- R7: The mask and clear registers read back the last value written to them.
- R8: Reads of unmapped offsets return 0. Writes to the status offset (0x10) or to unmapped offsets have no effect.
- R9: rdata_o is updated on the clock edge that samples a read access (cs_i=1, we_i=0). It holds its value on every other cycle.
- R10: Line 0 is active low: irq_req_i[0]=0 sets status bit 0. The other lines are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_LINES | Raw peripheral requests |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset from block base |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_no | output | 1 | Host interrupt, active low |

## Verification
A request first reaches irq_no on the third clock edge after it is applied. Two edges go to synchronization and one goes to the status capture. A status bit stuck at one would hold irq_no low when its mask bit is cleared, and it would read back wrong on the next status read. A wrong clear or mask bit shows up on the edge after the write, both in the read-back value and in the irq_no level. A latch that loses a bit shows up after a pulse ends, because the status read no longer reports that line.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int DW = 16;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_CLEAR  = 8'h20;
  localparam logic [7:0] OFS_MASK   = 8'h38;
  localparam logic [7:0] OFS_SIG_A  = 8'h40;
  localparam logic [7:0] OFS_SIG_B  = 8'h48;
  localparam logic [7:0] OFS_VER    = 8'h50;
  localparam logic [7:0] OFS_SIG_C  = 8'h58;
  localparam logic [DW-1:0] SIG_A = 16'hAAAA;
  localparam logic [DW-1:0] SIG_B = 16'h5555;
  localparam logic [DW-1:0] SIG_C = 16'hCAFE;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int N_LINES = 16,
  parameter int STAGES = 2,
  parameter logic [N_LINES-1:0] ACT_LOW = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] req_o
);
  logic [N_LINES-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      // normalise polarity so 1 means "request active"
      stage_q[0] <= raw_i ^ ACT_LOW;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign req_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
  parameter int N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] status_o
);
  logic [N_LINES-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q | req_i) & ~clr_i;  // clear wins
  end

  assign status_o = status_q;
endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
  import irqx_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int AW = 8,
  parameter logic [DW-1:0] VERSION = 16'h0107
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N_LINES-1:0] status_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] clr_o,
  output logic [DW-1:0]      rdata_o
);
  logic [N_LINES-1:0] mask_q, clr_q;
  logic [DW-1:0]      rdata_q, rd_mux;
  logic [7:0]         ofs;

  assign ofs = 8'(addr_i);

  always_comb begin
    rd_mux = '0;
    unique case (ofs)
      OFS_STATUS: rd_mux = DW'(status_i);
      OFS_CLEAR:  rd_mux = DW'(clr_q);
      OFS_MASK:   rd_mux = DW'(mask_q);
      OFS_SIG_A:  rd_mux = SIG_A;
      OFS_SIG_B:  rd_mux = SIG_B;
      OFS_VER:    rd_mux = VERSION;
      OFS_SIG_C:  rd_mux = SIG_C;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      clr_q   <= '0;
      rdata_q <= '0;
    end else if (cs_i) begin
      if (we_i) begin
        if (ofs == OFS_MASK)  mask_q <= wdata_i[N_LINES-1:0];
        if (ofs == OFS_CLEAR) clr_q  <= wdata_i[N_LINES-1:0];
      end else begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign mask_o  = mask_q;
  assign clr_o   = clr_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irqx_top.sv
module irqx_top
  import irqx_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] ACT_LOW = 16'h0001,
  parameter logic [15:0] VERSION = 16'h0107
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_req_i,
  input  logic               cs_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  output logic               irq_no
);
  logic [N_LINES-1:0] req_sync, status_q, mask_q, clr_q;

  irqx_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES), .ACT_LOW(ACT_LOW)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(irq_req_i), .req_o(req_sync)
  );

  irqx_status #(.N_LINES(N_LINES)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_sync), .clr_i(clr_q), .status_o(status_q)
  );

  irqx_regs #(.N_LINES(N_LINES), .AW(AW), .VERSION(VERSION)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status_q), .mask_o(mask_q), .clr_o(clr_q),
    .rdata_o(rdata_o)
  );

  assign irq_no = ~|(status_q & ~mask_q);
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int N_LINES = 16,
  parameter int AW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [15:0]        wdata_i,
  input logic [15:0]        rdata_o,
  input logic               irq_no,
  input logic [N_LINES-1:0] status_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] clr_q
);
  logic rd_acc;
  assign rd_acc = cs_i && !we_i;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(clr_q)) == '0));  // R5
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_q)) == '0));  // R2
  AST_FULL_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> irq_no);  // R6
  AST_SIG_A_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && addr_i == AW'(8'h40)) |=> (rdata_o == 16'hAAAA));  // R3
  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == AW'(8'h38)) |=> (mask_q == $past(wdata_i[N_LINES-1:0])));  // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> $stable(rdata_o));  // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && addr_i == AW'(8'h30)) |=> (rdata_o == 16'h0000));  // R8
endmodule

bind irqx_top irqx_checker #(.N_LINES(N_LINES), .AW(AW)) u_irqx_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no),
  .status_q(status_q), .mask_q(mask_q), .clr_q(clr_q)
);

// File: tb/test_irqx_top.sv
module test_irqx_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDLE_REQ = 16'h0001;  // line 0 idle high

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_req_i = IDLE_REQ;
  logic        cs_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_no;
  int checks = 0, failures = 0, cycles = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irqx_top i_irqx_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .cs_i(cs_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    cs_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    check("R1 rdata", rdata_o, 16'h0000);
    check("R1 irq_no", {15'b0, irq_no}, 16'h0001);
    bus_read(8'h38, rv); check("R1 mask", rv, 16'hFFFF);
    bus_read(8'h20, rv); check("R1 clear", rv, 16'h0000);
    bus_read(8'h10, rv); check("R1 status", rv, 16'h0000);
  endtask

  task automatic t_ident();
    bus_read(8'h40, rv); check("R3 sig 0x40", rv, 16'hAAAA);
    bus_read(8'h48, rv); check("R3 sig 0x48", rv, 16'h5555);
    bus_read(8'h58, rv); check("R3 sig 0x58", rv, 16'hCAFE);
    bus_read(8'h50, rv); check("R4 version", rv, 16'h0107);
    bus_write(8'h40, 16'h1234);
    bus_write(8'h58, 16'h0000);
    bus_read(8'h40, rv); check("R3 sig write ignored", rv, 16'hAAAA);
    bus_read(8'h58, rv); check("R3 sig write ignored", rv, 16'hCAFE);
  endtask

  task automatic t_latch_mask();
    bus_write(8'h38, 16'hFFDF);
    bus_read(8'h38, rv); check("R7 mask readback", rv, 16'hFFDF);
    @(negedge clk_i); irq_req_i = IDLE_REQ | 16'h0220;
    idle(2);
    irq_req_i = IDLE_REQ;
    idle(5);
    bus_read(8'h10, rv); check("R2 sticky status", rv, 16'h0220);
    check("R6 unmasked bit drives irq", {15'b0, irq_no}, 16'h0000);
    bus_write(8'h20, 16'h0020);
    bus_read(8'h10, rv); check("R5 clear bit 5", rv, 16'h0200);
    check("R6 masked bit keeps irq high", {15'b0, irq_no}, 16'h0001);
    bus_write(8'h20, 16'hFFFF);
    bus_write(8'h20, 16'h0000);
    bus_read(8'h10, rv); check("R5 clear all", rv, 16'h0000);
  endtask

  task automatic t_clear_hold();
    bus_write(8'h38, 16'hFFF7);
    @(negedge clk_i); irq_req_i = IDLE_REQ | 16'h0008;
    idle(5);
    check("R6 irq on line 3", {15'b0, irq_no}, 16'h0000);
    bus_write(8'h20, 16'h0008);
    idle(3);
    bus_read(8'h10, rv); check("R5 held clear while request active", rv, 16'h0000);
    check("R5 irq released under clear", {15'b0, irq_no}, 16'h0001);
    bus_read(8'h20, rv); check("R7 clear readback", rv, 16'h0008);
    bus_write(8'h20, 16'h0000);
    idle(2);
    bus_read(8'h10, rv); check("R5 relatch after release", rv, 16'h0008);
    @(negedge clk_i); irq_req_i = IDLE_REQ;
    idle(4);
    bus_write(8'h20, 16'hFFFF);
    bus_write(8'h20, 16'h0000);
  endtask

  task automatic t_line0();
    bus_write(8'h38, 16'hFFFE);
    idle(4);
    check("R10 idle-high line 0 quiet", {15'b0, irq_no}, 16'h0001);
    @(negedge clk_i); irq_req_i = 16'h0000;
    idle(4);
    bus_read(8'h10, rv); check("R10 active-low line 0", rv, 16'h0001);
    check("R10 irq from line 0", {15'b0, irq_no}, 16'h0000);
    @(negedge clk_i); irq_req_i = IDLE_REQ;
    idle(4);
    bus_write(8'h20, 16'h0001);
    bus_write(8'h20, 16'h0000);
    bus_read(8'h10, rv); check("R10 line 0 cleared", rv, 16'h0000);
  endtask

  task automatic t_unmapped();
    bus_read(8'h40, rv);
    bus_read(8'h30, rv); check("R8 unmapped read", rv, 16'h0000);
    bus_write(8'h10, 16'hFFFF);
    bus_write(8'h30, 16'hFFFF);
    bus_read(8'h10, rv); check("R8 status write ignored", rv, 16'h0000);
    bus_read(8'h38, rv); check("R8 mask untouched", rv, 16'hFFFE);
    bus_read(8'h20, rv); check("R8 clear untouched", rv, 16'h0000);
    check("R8 irq untouched", {15'b0, irq_no}, 16'h0001);
  endtask

  task automatic t_rdata_hold();
    bus_read(8'h48, rv);
    idle(3);
    check("R9 rdata holds when idle", rdata_o, 16'h5555);
    bus_write(8'h38, 16'h0F0F);
    check("R9 rdata holds across write", rdata_o, 16'h5555);
    bus_read(8'h38, rv); check("R9 rdata updated by read", rv, 16'h0F0F);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_ident();
    t_latch_mask();
    t_clear_hold();
    t_line0();
    t_unmapped();
    t_rdata_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule